// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address for a four-beat (by default) memory burst. On a load cycle it captures a complete address from its address input. On each advance cycle after that it moves the low address field to the next beat of the burst. The field width is set by `BURST_W`, which is 2 by default. The upper address field is captured on the load and then stays fixed until the next load, whatever appears on the address input in the meantime.

Two beat orders are available. Linear order adds the beat count to the start value and wraps inside the burst field. Interleaved order XORs the start value with the beat count. A strap input selects the order: 0 gives linear and 1 gives interleaved. Board logic should tie the strap high when it is not driven, so that interleaved order is the default. The design copies the strap into its state only on load cycles. A strap change in the middle of a burst therefore cannot disturb that burst. The active-low clock enable stalls the block completely: while it is high, load and advance requests are both ignored.

Top module: `burst_addr_gen`

## Requirements
- R1: A cycle with `rst` high sets `addr_out` to 0 on the next cycle, and this happens even while `ce_n` is high. An advance after reset with no load in between produces 1, 2, 3.
- R2: When `ce_n` is 0 and `adv_ld` is 0, `addr_out` equals the sampled `addr_in` one cycle later. Back-to-back loads each take effect.
- R3: In linear order (`order_n` = 0 at the load), the k-th advance after a load with low start value s gives a low field of (s + k) mod 2^BURST_W. For example, start 1 gives 2, 3, 0, 1.
- R4: In interleaved order (`order_n` = 1 at the load), the k-th advance gives a low field of s XOR (k mod 2^BURST_W). For example, start 2 gives 3, 0, 1, 2.
- R5: After 2^BURST_W advances the low field is back at its start value, and further advances repeat the same sequence until the next load.
- R6: During an advance the upper field `addr_out[ADDR_W-1:BURST_W]` does not change, and `addr_in` has no effect.
- R7: While `ce_n` is 1, `addr_out` holds its value whatever `adv_ld` and `addr_in` do. When `ce_n` returns to 0, the burst continues from the beat where it stopped.
- R8: The order is taken from `order_n` only on a load. Changing `order_n` during advances leaves the current burst in the order that was chosen at its load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Clock enable, active low; high stalls the block |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance to the next beat |
| order_n | input | 1 | Beat order strap: 0 linear, 1 interleaved (tie high by default) |
| addr_in | input | ADDR_W | Address sampled on load cycles |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with `ADDR_W` = 8 and `BURST_W` = 2. This keeps the upper field at six bits, so the all-ones address and upper-field values that differ from the input can both be checked directly. It also means every start value of the two-bit low field is reachable within a few vectors. With these values a full burst and its wrap take four advances, so the strap change partway through a burst, the stalls partway through a burst, and the repeat after four beats each fit in a short stretch of vectors.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        CMD_HOLD    = 2'd0,
        CMD_LOAD    = 2'd1,
        CMD_ADVANCE = 2'd2
    } burst_cmd_e;

    function automatic burst_cmd_e decode_cmd(input logic ce_n, input logic adv_ld);
        burst_cmd_e cmd;
        if (ce_n)
            cmd = CMD_HOLD;
        else if (adv_ld)
            cmd = CMD_ADVANCE;
        else
            cmd = CMD_LOAD;
        return cmd;
    endfunction

endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BURST_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  burst_cmd_e                cmd,
    input  logic [ADDR_W-1:0]         addr_in,
    input  logic                      order_n,
    output logic [ADDR_W-BURST_W-1:0] upper_q,
    output logic [BURST_W-1:0]        start_q,
    output burst_order_e              order_q
);
    // Captures the base address and beat order only on a load cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= ORDER_INTERLEAVED;
        end else if (cmd == CMD_LOAD) begin
            upper_q <= addr_in[ADDR_W-1:BURST_W];
            start_q <= addr_in[BURST_W-1:0];
            order_q <= burst_order_e'(order_n);
        end
    end
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
    import burst_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  burst_cmd_e         cmd,
    output logic [BURST_W-1:0] step_q
);
    localparam logic [BURST_W-1:0] STEP_ONE = {{(BURST_W-1){1'b0}}, 1'b1};

    // Beat counter: cleared by a load, wraps naturally at 2**BURST_W.
    always_ff @(posedge clk) begin
        if (rst)
            step_q <= '0;
        else begin
            case (cmd)
                CMD_LOAD:    step_q <= '0;
                CMD_ADVANCE: step_q <= step_q + STEP_ONE;
                default:     step_q <= step_q;
            endcase
        end
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] start,
    input  logic [BURST_W-1:0] step,
    input  burst_order_e       order,
    output logic [BURST_W-1:0] low
);
    logic [BURST_W-1:0] lin_low;
    logic [BURST_W-1:0] ilv_low;

    // Both variants are built per bit width; the order picks one.
    genvar b;
    generate
        for (b = 0; b < BURST_W; b++) begin : g_ilv
            assign ilv_low[b] = start[b] ^ step[b];
        end
    endgenerate

    assign lin_low = start + step;

    always_comb begin
        if (order == ORDER_INTERLEAVED)
            low = ilv_low;
        else
            low = lin_low;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_ld,
    input  logic              order_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UPPER_W = ADDR_W - BURST_W;

    burst_cmd_e         cmd;
    logic [UPPER_W-1:0] upper_q;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] step_q;
    logic [BURST_W-1:0] low;
    burst_order_e       order_q;

    always_comb cmd = decode_cmd(ce_n, adv_ld);

    burst_start_reg #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_start (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr_in (addr_in),
        .order_n (order_n),
        .upper_q (upper_q),
        .start_q (start_q),
        .order_q (order_q)
    );

    burst_step_ctr #(.BURST_W(BURST_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .step_q (step_q)
    );

    burst_order_map #(.BURST_W(BURST_W)) u_map (
        .start (start_q),
        .step  (step_q),
        .order (order_q),
        .low   (low)
    );

    assign addr_out = {upper_q, low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W  = 20,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              adv_ld,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            p_reset_zero_r1: assert (addr_out == '0)
                else $error("reset did not clear address");
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !adv_ld) |=> addr_out == $past(addr_in));

    p_advance_moves_r5: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adv_ld) |=> addr_out[BURST_W-1:0] != $past(addr_out[BURST_W-1:0]));

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adv_ld) |=> addr_out[ADDR_W-1:BURST_W] == $past(addr_out[ADDR_W-1:BURST_W]));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> $stable(addr_out));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .adv_ld   (adv_ld),
    .addr_in  (addr_in),
    .addr_out (addr_out)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 8;
    localparam int NV = 27;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic          order_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BURST_W(2)) uut (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .adv_ld   (adv_ld),
        .order_n  (order_n),
        .addr_in  (addr_in),
        .addr_out (addr_out)
    );

    // Vector: {req[3:0], adv_ld, ce_n, order_n, addr_in[7:0], expected[7:0]}
    localparam logic [22:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5}, // R2 load, linear
        {4'd6, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA6}, // R6 addr_in ignored, R3
        {4'd3, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA7}, // R3
        {4'd3, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA4}, // R3 wrap
        {4'd5, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA5}, // R5 back to start
        {4'd5, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA6}, // R5 repeats
        {4'd2, 1'b0, 1'b0, 1'b1, 8'h3E, 8'h3E}, // R2 load, interleaved
        {4'd4, 1'b1, 1'b0, 1'b1, 8'h00, 8'h3F}, // R4
        {4'd4, 1'b1, 1'b0, 1'b1, 8'h00, 8'h3C}, // R4
        {4'd4, 1'b1, 1'b0, 1'b1, 8'h00, 8'h3D}, // R4
        {4'd5, 1'b1, 1'b0, 1'b1, 8'h00, 8'h3E}, // R5
        {4'd7, 1'b1, 1'b1, 1'b1, 8'h00, 8'h3E}, // R7 stalled advance
        {4'd7, 1'b0, 1'b1, 1'b1, 8'h55, 8'h3E}, // R7 stalled load
        {4'd7, 1'b1, 1'b0, 1'b1, 8'h00, 8'h3F}, // R7 resumes at next beat
        {4'd2, 1'b0, 1'b0, 1'b1, 8'hC1, 8'hC1}, // R2
        {4'd8, 1'b1, 1'b0, 1'b0, 8'h00, 8'hC0}, // R8 strap flipped, stays interleaved
        {4'd8, 1'b1, 1'b0, 1'b0, 8'h00, 8'hC3}, // R8
        {4'd2, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF}, // R2 all ones
        {4'd2, 1'b0, 1'b0, 1'b0, 8'h02, 8'h02}, // R2 back-to-back load
        {4'd3, 1'b1, 1'b0, 1'b0, 8'h00, 8'h03}, // R3
        {4'd3, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00}, // R3 wrap
        {4'd2, 1'b0, 1'b0, 1'b1, 8'h0B, 8'h0B}, // R2
        {4'd4, 1'b1, 1'b0, 1'b1, 8'h00, 8'h0A}, // R4 start 3
        {4'd4, 1'b1, 1'b0, 1'b1, 8'h00, 8'h09}, // R4
        {4'd4, 1'b1, 1'b0, 1'b1, 8'h00, 8'h08}, // R4
        {4'd2, 1'b0, 1'b0, 1'b0, 8'hF3, 8'hF3}, // R2 load, linear
        {4'd8, 1'b1, 1'b0, 1'b1, 8'h00, 8'hF0}  // R8 stays linear
    };

    task automatic check(input logic [AW-1:0] exp, input string req);
        checks++;
        if (addr_out !== exp) begin
            fails++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(8'h00, "R1 reset");
        rst = 1'b0;
        adv_ld = 1'b1;
        @(negedge clk);
        check(8'h01, "R1 advance from reset");
        @(negedge clk);
        check(8'h02, "R1 advance from reset");
        @(negedge clk);
        check(8'h03, "R1 advance from reset");

        for (int i = 0; i < NV; i++) begin
            string tag;
            adv_ld  = VEC[i][18];
            ce_n    = VEC[i][17];
            order_n = VEC[i][16];
            addr_in = VEC[i][15:8];
            @(negedge clk);
            tag = $sformatf("R%0d vector %0d", VEC[i][22:19], i);
            check(VEC[i][7:0], tag);
        end

        // R1: reset wins over a stalled clock enable
        adv_ld = 1'b0; ce_n = 1'b0; addr_in = 8'h7D;
        @(negedge clk);
        check(8'h7D, "R2 load before reset");
        rst = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        check(8'h00, "R1 reset while stalled");
        rst = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        check(8'h00, "R7 stall after reset");
        finish_run();
    end

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end
endmodule